// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block holds the current power mode of a microcontroller-class system and decides, cycle by cycle, which mode changes are allowed. Software asks for a mode through a request strobe with a 3-bit mode code. The core signals a wait-for-interrupt/event instruction or the return from its last interrupt handler. Wake sources come in as one combined flag plus five wakeup pins. From the mode it holds, the block drives the enables for the main and low-power regulators, the CPU and flash clocks, SRAM2 retention and brown-out detection. It also raises a one-cycle system reset request when a mode change has to be turned into a reset.

The entry and exit rules are not symmetric. Low-power sleep is only reachable from low-power run. Stop 2 is only reachable from run. Stop 1 returns to whichever run mode it was entered from. Three active-low option inputs can replace entry into a deep mode group with a reset. Debug-hold inputs keep clocks and the regulator alive so that a debugger stays attached. A request the current mode does not allow leaves the mode as it is and sets a sticky error flag.

Top module: `lp_mode_seq`

## Requirements
- R1: After reset the mode is run, code 0. The main regulator, CPU clock, flash clock and brown-out detection are on, the low-power regulator is off, and err_o and sys_rst_req_o are low. Mode codes: run 0, low-power run 1, sleep 2, low-power sleep 3, stop 1 4, stop 2 5, standby 6, shutdown 7.
- R2: With sleep_on_exit_i low, a wfi_i strobe moves run to sleep and low-power run to low-power sleep. With sleep_on_exit_i high, wfi_i is ignored and an irq_ret_i strobe performs the same move. irq_ret_i is ignored when sleep_on_exit_i is low.
- R3: wake_i ends sleep (to run), low-power sleep (always to low-power run) and stop 2 (to run). It ends stop 1 in the run mode from which stop 1 was entered.
- R4: From low-power run, requests for sleep, stop 2 or low-power sleep are illegal. Low-power sleep is never a legal request. Stop 2 can only be requested from run.
- R5: Standby and shutdown exit to run, even when entered from low-power run. The exit is triggered by wake_i or by any wakeup pin whose level differs from its wkup_pol_i bit (1 = active low).
- R6: The main regulator is on in run and sleep. The low-power regulator is on in low-power run, low-power sleep, stop 1 and stop 2. Both are off in standby and shutdown, except that standby with sram2_ret_i high keeps the low-power regulator on and drives sram2_ret_o high.
- R7: In stop 1 with stop1_main_i high, the main regulator stays on and the low-power regulator is off. In stop 2 the main regulator is always off.
- R8: When an active-low option input is 0, a request for its group (opt_n_i[0] stop 1/stop 2, opt_n_i[1] standby, opt_n_i[2] shutdown) does not enter the mode. The block instead pulses sys_rst_req_o for one cycle and returns to run.
- R9: Brown-out detection is on in every mode except shutdown. Leaving shutdown pulses sys_rst_req_o for one cycle.
- R10: dbg_hold_i[0] keeps the CPU clock on in sleep and low-power sleep. dbg_hold_i[1] keeps the CPU and flash clocks on in the stop modes. dbg_hold_i[2] keeps the main regulator and the clocks on in standby and shutdown.
- R11: An illegal request, or any request while in a mode other than run or low-power run, leaves the mode unchanged and sets err_o, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Mode request strobe |
| req_mode_i | input | 3 | Requested mode code |
| wfi_i | input | 1 | Wait-for-interrupt/event strobe |
| irq_ret_i | input | 1 | Return from lowest-priority handler |
| sleep_on_exit_i | input | 1 | Enter sleep on handler return instead of on wfi |
| wake_i | input | 1 | Combined wake event |
| wkup_pin_i | input | 5 | Wakeup pin levels |
| wkup_pol_i | input | 5 | Per-pin polarity, 1 = active low |
| opt_n_i | input | 3 | Active-low reset-on-entry options |
| sram2_ret_i | input | 1 | Retain SRAM2 in standby |
| stop1_main_i | input | 1 | Keep main regulator in stop 1 |
| dbg_hold_i | input | 3 | Debug hold bits |
| mode_o | output | 3 | Current mode code |
| main_reg_en_o | output | 1 | Main regulator enable |
| lp_reg_en_o | output | 1 | Low-power regulator enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| flash_clk_en_o | output | 1 | Flash clock enable |
| sram2_ret_o | output | 1 | SRAM2 supply/retention enable |
| bor_en_o | output | 1 | Brown-out detection enable |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| err_o | output | 1 | Sticky illegal-request flag |

## Verification
A vector table walks the mode graph along paths that differ only in the run mode they start from. This shows that stop 1 returns to its origin while standby and shutdown always return to run. Directed sequences toggle sleep_on_exit_i, so that the two sleep triggers can be told apart, and set each option bit alone to separate reset-on-entry from normal entry. Pin polarity is driven at both levels to show that an idle pin does not wake the block and an active one does. Regulator and clock outputs are read in each mode with the retention, stop-1 regulator and debug bits both set and cleared.

// File: rtl/lp_mode_pkg.sv
package lp_mode_pkg;
  localparam int MODE_W = 3;
  typedef enum logic [MODE_W-1:0] {
    M_RUN     = 3'd0,
    M_LPRUN   = 3'd1,
    M_SLEEP   = 3'd2,
    M_LPSLEEP = 3'd3,
    M_STOP1   = 3'd4,
    M_STOP2   = 3'd5,
    M_STBY    = 3'd6,
    M_SHDN    = 3'd7
  } lp_mode_e;
  localparam int OPT_STOP = 0;
  localparam int OPT_STBY = 1;
  localparam int OPT_SHDN = 2;
  localparam int NUM_OPT  = 3;
  localparam int DBG_SLP  = 0;
  localparam int DBG_STOP = 1;
  localparam int DBG_STBY = 2;
  localparam int NUM_DBG  = 3;
endpackage

// File: rtl/lp_wake_match.sv
module lp_wake_match #(
  parameter int NUM_WKUP = 5
) (
  input  logic [NUM_WKUP-1:0] pin_i,
  input  logic [NUM_WKUP-1:0] pol_i,
  output logic                hit_o
);
  logic [NUM_WKUP-1:0] hit;
  for (genvar g = 0; g < NUM_WKUP; g++) begin : g_pin
    // pol=1: active low
    assign hit[g] = pin_i[g] ^ pol_i[g];
  end
  assign hit_o = |hit;
endmodule

// File: rtl/lp_mode_legal.sv
module lp_mode_legal
  import lp_mode_pkg::*;
(
  input  lp_mode_e             cur_i,
  input  lp_mode_e             req_i,
  input  logic [NUM_OPT-1:0]   opt_n_i,
  output logic                 legal_o,
  output logic                 rst_entry_o
);
  always_comb begin
    legal_o = 1'b0;
    unique case (cur_i)
      M_RUN:   legal_o = (req_i != M_LPSLEEP);
      M_LPRUN: legal_o = (req_i == M_RUN) || (req_i == M_LPRUN) || (req_i == M_STOP1) ||
                         (req_i == M_STBY) || (req_i == M_SHDN);
      default: legal_o = 1'b0;
    endcase
  end

  always_comb begin
    rst_entry_o = 1'b0;
    unique case (req_i)
      M_STOP1, M_STOP2: rst_entry_o = !opt_n_i[OPT_STOP];
      M_STBY:           rst_entry_o = !opt_n_i[OPT_STBY];
      M_SHDN:           rst_entry_o = !opt_n_i[OPT_SHDN];
      default:          rst_entry_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
  import lp_mode_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_valid_i,
  input  lp_mode_e req_mode_i,
  input  logic     req_legal_i,
  input  logic     req_rst_i,
  input  logic     wfi_i,
  input  logic     irq_ret_i,
  input  logic     sleep_on_exit_i,
  input  logic     wake_i,
  input  logic     pin_hit_i,
  output lp_mode_e mode_o,
  output logic     rst_req_o,
  output logic     err_o
);
  lp_mode_e mode_q, mode_d;
  logic     from_lp_q, from_lp_d;
  logic     err_q, set_err;
  logic     rst_q, rst_d;
  logic     sleep_trig;
  logic     in_run;

  assign in_run     = (mode_q == M_RUN) || (mode_q == M_LPRUN);
  assign sleep_trig = sleep_on_exit_i ? irq_ret_i : wfi_i;

  always_comb begin
    mode_d    = mode_q;
    from_lp_d = from_lp_q;
    set_err   = 1'b0;
    rst_d     = 1'b0;
    unique case (mode_q)
      M_RUN, M_LPRUN: begin
        if (req_valid_i) begin
          if (!req_legal_i) begin
            set_err = 1'b1;
          end else if (req_rst_i) begin
            mode_d    = M_RUN;
            from_lp_d = 1'b0;
            rst_d     = 1'b1;
          end else begin
            mode_d = req_mode_i;
            if (req_mode_i == M_STOP1) from_lp_d = (mode_q == M_LPRUN);
          end
        end else if (sleep_trig) begin
          mode_d = (mode_q == M_LPRUN) ? M_LPSLEEP : M_SLEEP;
        end
      end
      M_SLEEP:   if (wake_i) mode_d = M_RUN;
      M_LPSLEEP: if (wake_i) mode_d = M_LPRUN;
      M_STOP1:   if (wake_i) mode_d = from_lp_q ? M_LPRUN : M_RUN;
      M_STOP2:   if (wake_i) mode_d = M_RUN;
      M_STBY:    if (wake_i || pin_hit_i) mode_d = M_RUN;
      M_SHDN: begin
        if (wake_i || pin_hit_i) begin
          mode_d = M_RUN;
          rst_d  = 1'b1;
        end
      end
      default: mode_d = M_RUN;
    endcase
    if (req_valid_i && !in_run) set_err = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= M_RUN;
      from_lp_q <= 1'b0;
      err_q     <= 1'b0;
      rst_q     <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      from_lp_q <= from_lp_d;
      err_q     <= err_q | set_err;
      rst_q     <= rst_d;
    end
  end

  assign mode_o    = mode_q;
  assign rst_req_o = rst_q;
  assign err_o     = err_q;
endmodule

// File: rtl/lp_power_ctrl.sv
module lp_power_ctrl
  import lp_mode_pkg::*;
(
  input  lp_mode_e           mode_i,
  input  logic               sram2_ret_i,
  input  logic               stop1_main_i,
  input  logic [NUM_DBG-1:0] dbg_hold_i,
  output logic               main_reg_o,
  output logic               lp_reg_o,
  output logic               cpu_clk_o,
  output logic               flash_clk_o,
  output logic               sram2_o,
  output logic               bor_o
);
  always_comb begin
    main_reg_o  = 1'b0;
    lp_reg_o    = 1'b0;
    cpu_clk_o   = 1'b0;
    flash_clk_o = 1'b0;
    sram2_o     = 1'b1;
    bor_o       = 1'b1;
    unique case (mode_i)
      M_RUN: begin
        main_reg_o = 1'b1; cpu_clk_o = 1'b1; flash_clk_o = 1'b1;
      end
      M_LPRUN: begin
        lp_reg_o = 1'b1; cpu_clk_o = 1'b1; flash_clk_o = 1'b1;
      end
      M_SLEEP: begin
        main_reg_o = 1'b1; flash_clk_o = 1'b1; cpu_clk_o = dbg_hold_i[DBG_SLP];
      end
      M_LPSLEEP: begin
        lp_reg_o = 1'b1; flash_clk_o = 1'b1; cpu_clk_o = dbg_hold_i[DBG_SLP];
      end
      M_STOP1: begin
        main_reg_o  = stop1_main_i;
        lp_reg_o    = !stop1_main_i;
        cpu_clk_o   = dbg_hold_i[DBG_STOP];
        flash_clk_o = dbg_hold_i[DBG_STOP];
      end
      M_STOP2: begin
        lp_reg_o    = 1'b1;
        cpu_clk_o   = dbg_hold_i[DBG_STOP];
        flash_clk_o = dbg_hold_i[DBG_STOP];
      end
      M_STBY: begin
        main_reg_o  = dbg_hold_i[DBG_STBY];
        lp_reg_o    = sram2_ret_i;
        sram2_o     = sram2_ret_i;
        cpu_clk_o   = dbg_hold_i[DBG_STBY];
        flash_clk_o = dbg_hold_i[DBG_STBY];
      end
      M_SHDN: begin
        main_reg_o  = dbg_hold_i[DBG_STBY];
        sram2_o     = 1'b0;
        bor_o       = 1'b0;
        cpu_clk_o   = dbg_hold_i[DBG_STBY];
        flash_clk_o = dbg_hold_i[DBG_STBY];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lp_mode_seq.sv
module lp_mode_seq
  import lp_mode_pkg::*;
#(
  parameter int NUM_WKUP = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [MODE_W-1:0]   req_mode_i,
  input  logic                wfi_i,
  input  logic                irq_ret_i,
  input  logic                sleep_on_exit_i,
  input  logic                wake_i,
  input  logic [NUM_WKUP-1:0] wkup_pin_i,
  input  logic [NUM_WKUP-1:0] wkup_pol_i,
  input  logic [NUM_OPT-1:0]  opt_n_i,
  input  logic                sram2_ret_i,
  input  logic                stop1_main_i,
  input  logic [NUM_DBG-1:0]  dbg_hold_i,
  output logic [MODE_W-1:0]   mode_o,
  output logic                main_reg_en_o,
  output logic                lp_reg_en_o,
  output logic                cpu_clk_en_o,
  output logic                flash_clk_en_o,
  output logic                sram2_ret_o,
  output logic                bor_en_o,
  output logic                sys_rst_req_o,
  output logic                err_o
);
  lp_mode_e mode, req_mode;
  logic     legal, rst_entry, pin_hit;

  assign req_mode = lp_mode_e'(req_mode_i);

  lp_wake_match #(.NUM_WKUP(NUM_WKUP)) u_wake (
    .pin_i (wkup_pin_i),
    .pol_i (wkup_pol_i),
    .hit_o (pin_hit)
  );

  lp_mode_legal u_legal (
    .cur_i       (mode),
    .req_i       (req_mode),
    .opt_n_i     (opt_n_i),
    .legal_o     (legal),
    .rst_entry_o (rst_entry)
  );

  lp_mode_fsm u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_mode_i      (req_mode),
    .req_legal_i     (legal),
    .req_rst_i       (rst_entry),
    .wfi_i           (wfi_i),
    .irq_ret_i       (irq_ret_i),
    .sleep_on_exit_i (sleep_on_exit_i),
    .wake_i          (wake_i),
    .pin_hit_i       (pin_hit),
    .mode_o          (mode),
    .rst_req_o       (sys_rst_req_o),
    .err_o           (err_o)
  );

  lp_power_ctrl u_pwr (
    .mode_i       (mode),
    .sram2_ret_i  (sram2_ret_i),
    .stop1_main_i (stop1_main_i),
    .dbg_hold_i   (dbg_hold_i),
    .main_reg_o   (main_reg_en_o),
    .lp_reg_o     (lp_reg_en_o),
    .cpu_clk_o    (cpu_clk_en_o),
    .flash_clk_o  (flash_clk_en_o),
    .sram2_o      (sram2_ret_o),
    .bor_o        (bor_en_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/lp_mode_seq_chk.sv
module lp_mode_seq_chk
  import lp_mode_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [MODE_W-1:0] mode_o,
  input logic              main_reg_en_o,
  input logic              bor_en_o,
  input logic              sys_rst_req_o,
  input logic              err_o
);
  // R4
  lpsleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_LPSLEEP && $past(mode_o) != M_LPSLEEP) |-> $past(mode_o) == M_LPRUN);
  // R4
  stop2_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_STOP2 && $past(mode_o) != M_STOP2) |-> $past(mode_o) == M_RUN);
  // R3
  lpsleep_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == M_LPSLEEP && mode_o != M_LPSLEEP) |-> mode_o == M_LPRUN);
  // R7
  stop2_no_main_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == M_STOP2 |-> !main_reg_en_o);
  // R9
  shdn_exit_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == M_SHDN && mode_o != M_SHDN) |-> sys_rst_req_o);
  // R9
  bor_shdn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bor_en_o == (mode_o != M_SHDN));
  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R11
  req_in_lp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_o != M_RUN && mode_o != M_LPRUN) |=> (err_o && $stable(mode_o)));
endmodule

bind lp_mode_seq lp_mode_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .mode_o        (mode_o),
  .main_reg_en_o (main_reg_en_o),
  .bor_en_o      (bor_en_o),
  .sys_rst_req_o (sys_rst_req_o),
  .err_o         (err_o)
);

// File: tb/tb_lp_mode_seq.sv
module tb_lp_mode_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [2:0] req_mode_i = 3'd0;
  logic       wfi_i = 1'b0;
  logic       irq_ret_i = 1'b0;
  logic       sleep_on_exit_i = 1'b0;
  logic       wake_i = 1'b0;
  logic [4:0] wkup_pin_i = 5'd0;
  logic [4:0] wkup_pol_i = 5'd0;
  logic [2:0] opt_n_i = 3'b111;
  logic       sram2_ret_i = 1'b1;
  logic       stop1_main_i = 1'b0;
  logic [2:0] dbg_hold_i = 3'd0;
  logic [2:0] mode_o;
  logic main_reg_en_o, lp_reg_en_o, cpu_clk_en_o, flash_clk_en_o;
  logic sram2_ret_o, bor_en_o, sys_rst_req_o, err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  lp_mode_seq dut (.*);

  localparam logic [2:0] RUN = 3'd0, LPRUN = 3'd1, SLEEP = 3'd2, LPSLEEP = 3'd3,
                         STOP1 = 3'd4, STOP2 = 3'd5, STBY = 3'd6, SHDN = 3'd7;
  localparam logic [2:0] OP_REQ = 3'd0, OP_WFI = 3'd1, OP_IRQ = 3'd2, OP_WAKE = 3'd3,
                         OP_PIN = 3'd4;
  localparam int NV = 19;
  // {op, arg, expected mode, expected reset pulse}
  localparam logic [11:0] VECS [0:NV-1] = '{
    {OP_REQ,  5'd1, LPRUN,   1'b0},
    {OP_WFI,  5'd0, LPSLEEP, 1'b0},
    {OP_WAKE, 5'd0, LPRUN,   1'b0},
    {OP_REQ,  5'd4, STOP1,   1'b0},
    {OP_WAKE, 5'd0, LPRUN,   1'b0},
    {OP_REQ,  5'd6, STBY,    1'b0},
    {OP_PIN,  5'b00100, RUN, 1'b0},
    {OP_WFI,  5'd0, SLEEP,   1'b0},
    {OP_WAKE, 5'd0, RUN,     1'b0},
    {OP_REQ,  5'd5, STOP2,   1'b0},
    {OP_WAKE, 5'd0, RUN,     1'b0},
    {OP_REQ,  5'd4, STOP1,   1'b0},
    {OP_WAKE, 5'd0, RUN,     1'b0},
    {OP_REQ,  5'd7, SHDN,    1'b0},
    {OP_WAKE, 5'd0, RUN,     1'b1},
    {OP_REQ,  5'd1, LPRUN,   1'b0},
    {OP_REQ,  5'd7, SHDN,    1'b0},
    {OP_PIN,  5'b00001, RUN, 1'b1},
    {OP_REQ,  5'd0, RUN,     1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one op for one cycle, sample at the following negedge
  task automatic op(input logic [2:0] kind, input logic [4:0] arg);
    case (kind)
      OP_REQ:  begin req_valid_i = 1'b1; req_mode_i = arg[2:0]; end
      OP_WFI:  wfi_i = 1'b1;
      OP_IRQ:  irq_ret_i = 1'b1;
      OP_WAKE: wake_i = 1'b1;
      default: wkup_pin_i = arg;
    endcase
    @(negedge clk_i);
    req_valid_i = 1'b0; wfi_i = 1'b0; irq_ret_i = 1'b0; wake_i = 1'b0;
    wkup_pin_i = 5'd0;
    #1;
  endtask

  task automatic reset_dut();
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    // R1 reset state
    chk("R1 mode", {5'd0, mode_o}, {5'd0, RUN});
    chk("R1 outs", {2'd0, main_reg_en_o, lp_reg_en_o, cpu_clk_en_o, flash_clk_en_o, bor_en_o, err_o},
        8'b0010_1110);
    chk("R1 rst", {7'd0, sys_rst_req_o}, 8'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R3 R4 R5 R9 table walk
    for (int i = 0; i < NV; i++) begin
      op(VECS[i][11:9], VECS[i][8:4]);
      chk($sformatf("R3 R5 vec%0d mode", i), {5'd0, mode_o}, {5'd0, VECS[i][3:1]});
      chk($sformatf("R9 vec%0d rst", i), {7'd0, sys_rst_req_o}, {7'd0, VECS[i][0]});
    end
    chk("R11 no err after legal walk", {7'd0, err_o}, 8'd0);

    // R6 regulators per mode
    op(OP_REQ, 5'd1);
    chk("R6 lprun regs", {6'd0, main_reg_en_o, lp_reg_en_o}, 8'b01);
    op(OP_REQ, 5'd0);
    op(OP_WFI, 5'd0);
    chk("R6 sleep regs/cpu", {5'd0, main_reg_en_o, lp_reg_en_o, cpu_clk_en_o}, 8'b100);
    dbg_hold_i = 3'b001; #1;
    chk("R10 sleep dbg cpu", {7'd0, cpu_clk_en_o}, 8'd1);
    dbg_hold_i = 3'b000;
    op(OP_WAKE, 5'd0);
    op(OP_REQ, 5'd6);
    chk("R6 stby ret regs", {5'd0, main_reg_en_o, lp_reg_en_o, sram2_ret_o}, 8'b011);
    sram2_ret_i = 1'b0; #1;
    chk("R6 stby noret regs", {5'd0, main_reg_en_o, lp_reg_en_o, sram2_ret_o}, 8'b000);
    sram2_ret_i = 1'b1;
    op(OP_WAKE, 5'd0);
    chk("R5 stby wake", {5'd0, mode_o}, {5'd0, RUN});

    // R7 stop 1 / stop 2 main regulator option
    stop1_main_i = 1'b1;
    op(OP_REQ, 5'd4);
    chk("R7 stop1 main", {6'd0, main_reg_en_o, lp_reg_en_o}, 8'b10);
    op(OP_WAKE, 5'd0);
    op(OP_REQ, 5'd5);
    chk("R7 stop2 no main", {6'd0, main_reg_en_o, lp_reg_en_o}, 8'b01);
    dbg_hold_i = 3'b010; #1;
    chk("R10 stop dbg clocks", {6'd0, cpu_clk_en_o, flash_clk_en_o}, 8'b11);
    dbg_hold_i = 3'b000; stop1_main_i = 1'b0;
    op(OP_WAKE, 5'd0);

    // R9 R10 shutdown with debug hold
    op(OP_REQ, 5'd7);
    chk("R9 shdn bor", {6'd0, bor_en_o, main_reg_en_o}, 8'b00);
    dbg_hold_i = 3'b100; #1;
    chk("R10 shdn dbg", {6'd0, main_reg_en_o, cpu_clk_en_o}, 8'b11);
    dbg_hold_i = 3'b000;
    op(OP_WAKE, 5'd0);
    chk("R9 shdn exit rst", {4'd0, sys_rst_req_o, mode_o}, {4'd0, 1'b1, RUN});
    @(negedge clk_i); #1;
    chk("R9 rst one cycle", {7'd0, sys_rst_req_o}, 8'd0);

    // R8 option bits
    opt_n_i = 3'b110;
    op(OP_REQ, 5'd5);
    chk("R8 stop2 opt", {4'd0, sys_rst_req_o, mode_o}, {4'd0, 1'b1, RUN});
    op(OP_REQ, 5'd1);
    op(OP_REQ, 5'd4);
    chk("R8 stop1 opt from lprun", {4'd0, sys_rst_req_o, mode_o}, {4'd0, 1'b1, RUN});
    opt_n_i = 3'b101;
    op(OP_REQ, 5'd4);
    chk("R8 stop1 allowed", {4'd0, sys_rst_req_o, mode_o}, {4'd0, 1'b0, STOP1});
    op(OP_WAKE, 5'd0);
    op(OP_REQ, 5'd6);
    chk("R8 stby opt", {4'd0, sys_rst_req_o, mode_o}, {4'd0, 1'b1, RUN});
    opt_n_i = 3'b011;
    op(OP_REQ, 5'd7);
    chk("R8 shdn opt", {4'd0, sys_rst_req_o, mode_o}, {4'd0, 1'b1, RUN});
    opt_n_i = 3'b111;

    // R2 sleep-on-exit
    sleep_on_exit_i = 1'b1;
    op(OP_WFI, 5'd0);
    chk("R2 wfi ignored", {5'd0, mode_o}, {5'd0, RUN});
    op(OP_IRQ, 5'd0);
    chk("R2 irq_ret sleep", {5'd0, mode_o}, {5'd0, SLEEP});
    op(OP_WAKE, 5'd0);
    op(OP_REQ, 5'd1);
    op(OP_IRQ, 5'd0);
    chk("R2 irq_ret lpsleep", {5'd0, mode_o}, {5'd0, LPSLEEP});
    op(OP_WAKE, 5'd0);
    sleep_on_exit_i = 1'b0;
    op(OP_IRQ, 5'd0);
    chk("R2 irq_ret ignored", {5'd0, mode_o}, {5'd0, LPRUN});

    // R5 pin polarity: pin 3 active low, held high is idle
    op(OP_REQ, 5'd0);
    op(OP_REQ, 5'd6);
    wkup_pol_i = 5'b01000;
    wkup_pin_i = 5'b01000;
    @(negedge clk_i); @(negedge clk_i); #1;
    chk("R5 idle pin no wake", {5'd0, mode_o}, {5'd0, STBY});
    op(OP_PIN, 5'b00000);
    chk("R5 active-low wake", {5'd0, mode_o}, {5'd0, RUN});
    wkup_pol_i = 5'b00000;

    // R4 R11 illegal requests
    chk("R11 err clear", {7'd0, err_o}, 8'd0);
    op(OP_REQ, 5'd1);
    op(OP_REQ, 5'd2);
    chk("R4 lprun->sleep held", {4'd0, err_o, mode_o}, {4'd0, 1'b1, LPRUN});
    op(OP_REQ, 5'd5);
    chk("R4 lprun->stop2 held", {5'd0, mode_o}, {5'd0, LPRUN});
    op(OP_REQ, 5'd0);
    op(OP_REQ, 5'd3);
    chk("R4 run->lpsleep held", {5'd0, mode_o}, {5'd0, RUN});
    op(OP_REQ, 5'd4);
    op(OP_REQ, 5'd0);
    chk("R11 req in stop1 held", {4'd0, err_o, mode_o}, {4'd0, 1'b1, STOP1});
    op(OP_WAKE, 5'd0);
    chk("R11 err sticky", {4'd0, err_o, mode_o}, {4'd0, 1'b1, RUN});
    reset_dut();
    chk("R1 err cleared by reset", {7'd0, err_o}, 8'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule